// File: doc/BRIEF.md
# BCD Minute-Second Clock with Windowed Alarm

The block keeps a minutes:seconds time of day as two packed BCD bytes (tens digit in the upper nibble, units in the lower). A one-cycle clock-enable pulse, arriving once per second, advances the time by one second. After reset the time starts at 57:05.

The four digits drive a multiplexed seven-segment display. There is one shared segment bus and a four-bit active-low digit-select bus. A separate scan pulse moves the display on to the next digit.

A buzzer output toggles while the time is inside a fixed alarm window. The window is one minute value plus an inclusive range of seconds, and all three bounds are parameters. The buzzer is driven by a divider clocked on a third pulse input, called the beep tick.

Top module: `bcd_alarm_clock`

## Requirements
- R1: When reset is released, the time reads 57:05: min_o = 0x57 and sec_o = 0x05. The scan position is seconds-units, and buzz_o is 0.
- R2: Each cycle with sec_tick_i high adds one second. The BCD units digit wraps from 9 to 0 and carries into the tens digit. Cycles without the tick leave the time unchanged.
- R3: Seconds wrap from 0x59 to 0x00 and carry into minutes. Minutes wrap from 0x59 to 0x00, so 59:59 becomes 00:00.
- R4: The display scans digits in a fixed order, with this active-low select on dig_sel_no: seconds-units 4'b0111, seconds-tens 4'b1011, minutes-units 4'b1101, minutes-tens 4'b1110. After minutes-tens it returns to seconds-units. The scan moves one step per cycle with scan_tick_i high, and exactly one select bit is low at all times.
- R5: seg_o shows the digit currently selected. Bit 0 is segment a and bit 6 is segment g. The codes for digits 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x67.
- R6: alarm_o is high exactly when the minute is 0x57 and the seconds are from 0x10 to 0x14 inclusive.
- R7: While the alarm is active, buzz_o inverts after every 10 beep ticks. It starts low on entry to the window, giving 10 ticks high and 10 ticks low.
- R8: Outside the window, buzz_o is held at 0 and the beep divider is cleared, so beep ticks have no effect there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sec_tick_i | input | 1 | One-second enable pulse |
| scan_tick_i | input | 1 | Display scan enable pulse |
| beep_tick_i | input | 1 | Buzzer divider enable pulse |
| min_o | output | 8 | Minutes, packed BCD |
| sec_o | output | 8 | Seconds, packed BCD |
| seg_o | output | 7 | Segment drive, bit 0 = a |
| dig_sel_no | output | 4 | Active-low digit select |
| alarm_o | output | 1 | Alarm window active |
| buzz_o | output | 1 | Buzzer drive |

## Verification
The tightest coincidence is a seconds tick and a beep tick in the same cycle while the time crosses a window edge. The tick that enters 57:10 must restart the divider rather than count. The tick that leaves 57:14 must force buzz_o low even when the divider would have toggled. The bench drives the two pulses together at 57:09 and at 57:14. It then checks that buzz_o and the divider phase follow a model that treats entry and exit as taking priority. A scan tick landing with a seconds carry is also checked: the segment bus must show the new digit value on the next cycle.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;
  localparam int unsigned DIGITS = 4;
  localparam int unsigned SEG_W  = 7;

  typedef enum logic [1:0] {
    POS_SEC_LO = 2'd0,
    POS_SEC_HI = 2'd1,
    POS_MIN_LO = 2'd2,
    POS_MIN_HI = 2'd3
  } scan_pos_e;

  function automatic logic [SEG_W-1:0] seg_code(input logic [3:0] d);
    logic [SEG_W-1:0] r;
    unique case (d)
      4'd0: r = 7'h3F;
      4'd1: r = 7'h06;
      4'd2: r = 7'h5B;
      4'd3: r = 7'h4F;
      4'd4: r = 7'h66;
      4'd5: r = 7'h6D;
      4'd6: r = 7'h7D;
      4'd7: r = 7'h07;
      4'd8: r = 7'h7F;
      4'd9: r = 7'h67;
      default: r = 7'h00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bcd_counter60.sv
// Two-digit BCD counter 00..59 with carry out on wrap.
module bcd_counter60 #(
  parameter logic [7:0] INIT = 8'h00,
  parameter logic [3:0] HI_MAX = 4'd5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  logic [3:0] lo_q, hi_q;
  logic lo_top, hi_top;

  assign lo_top = (lo_q == 4'd9);
  assign hi_top = (hi_q == HI_MAX);
  assign wrap_o = inc_i && lo_top && hi_top;
  assign val_o  = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= INIT[3:0];
      hi_q <= INIT[7:4];
    end else if (inc_i) begin
      if (lo_top) begin
        lo_q <= 4'd0;
        hi_q <= hi_top ? 4'd0 : hi_q + 4'd1;
      end else begin
        lo_q <= lo_q + 4'd1;
      end
    end
  end
endmodule

// File: rtl/digit_scanner.sv
module digit_scanner
  import bcd_clock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_tick_i,
  input  logic [7:0]       min_i,
  input  logic [7:0]       sec_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [DIGITS-1:0] dig_sel_no
);
  logic [1:0] pos_q;
  logic [3:0] digit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pos_q <= POS_SEC_LO;
    else if (scan_tick_i) pos_q <= pos_q + 2'd1;
  end

  always_comb begin
    unique case (scan_pos_e'(pos_q))
      POS_SEC_LO: digit = sec_i[3:0];
      POS_SEC_HI: digit = sec_i[7:4];
      POS_MIN_LO: digit = min_i[3:0];
      default:    digit = min_i[7:4];
    endcase
  end

  // position 0 drives the MSB low
  for (genvar g = 0; g < DIGITS; g++) begin : g_sel
    assign dig_sel_no[DIGITS-1-g] = (pos_q != 2'(g));
  end

  assign seg_o = seg_code(digit);
endmodule

// File: rtl/alarm_beeper.sv
module alarm_beeper #(
  parameter logic [7:0] ALM_MIN    = 8'h57,
  parameter logic [7:0] ALM_SEC_LO = 8'h10,
  parameter logic [7:0] ALM_SEC_HI = 8'h14,
  parameter int unsigned HALF_TICKS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       beep_tick_i,
  input  logic [7:0] min_i,
  input  logic [7:0] sec_i,
  output logic       alarm_o,
  output logic       buzz_o
);
  localparam int unsigned CW = $clog2(HALF_TICKS + 1);
  logic [CW-1:0] cnt_q;
  logic buzz_q;

  // BCD compares correctly as plain binary
  assign alarm_o = (min_i == ALM_MIN) && (sec_i >= ALM_SEC_LO) && (sec_i <= ALM_SEC_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      buzz_q <= 1'b0;
    end else if (!alarm_o) begin
      cnt_q  <= '0;
      buzz_q <= 1'b0;
    end else if (beep_tick_i) begin
      if (cnt_q == CW'(HALF_TICKS - 1)) begin
        cnt_q  <= '0;
        buzz_q <= ~buzz_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign buzz_o = buzz_q && alarm_o;
endmodule

// File: rtl/bcd_alarm_clock.sv
module bcd_alarm_clock
  import bcd_clock_pkg::*;
#(
  parameter logic [7:0] INIT_MIN   = 8'h57,
  parameter logic [7:0] INIT_SEC   = 8'h05,
  parameter logic [7:0] ALM_MIN    = 8'h57,
  parameter logic [7:0] ALM_SEC_LO = 8'h10,
  parameter logic [7:0] ALM_SEC_HI = 8'h14,
  parameter int unsigned HALF_TICKS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_tick_i,
  input  logic       scan_tick_i,
  input  logic       beep_tick_i,
  output logic [7:0] min_o,
  output logic [7:0] sec_o,
  output logic [6:0] seg_o,
  output logic [3:0] dig_sel_no,
  output logic       alarm_o,
  output logic       buzz_o
);
  logic sec_wrap, min_wrap;

  bcd_counter60 #(.INIT(INIT_SEC)) u_sec (
    .clk_i, .rst_ni, .inc_i(sec_tick_i), .val_o(sec_o), .wrap_o(sec_wrap)
  );

  bcd_counter60 #(.INIT(INIT_MIN)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_wrap), .val_o(min_o), .wrap_o(min_wrap)
  );

  digit_scanner u_scan (
    .clk_i, .rst_ni, .scan_tick_i, .min_i(min_o), .sec_i(sec_o),
    .seg_o, .dig_sel_no
  );

  alarm_beeper #(
    .ALM_MIN(ALM_MIN), .ALM_SEC_LO(ALM_SEC_LO), .ALM_SEC_HI(ALM_SEC_HI),
    .HALF_TICKS(HALF_TICKS)
  ) u_alarm (
    .clk_i, .rst_ni, .beep_tick_i, .min_i(min_o), .sec_i(sec_o),
    .alarm_o, .buzz_o
  );

  logic unused_wrap;
  assign unused_wrap = min_wrap;
endmodule

// File: rtl/bcd_alarm_clock_chk.sv
module bcd_alarm_clock_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sec_tick_i,
  input logic [7:0] min_o,
  input logic [7:0] sec_o,
  input logic [3:0] dig_sel_no,
  input logic       alarm_o,
  input logic       buzz_o
);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_tick_i |=> $stable(sec_o) && $stable(min_o));

  p_bcd_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o[7:4] <= 4'd5 && sec_o[3:0] <= 4'd9 && min_o[7:4] <= 4'd5 && min_o[3:0] <= 4'd9);

  p_sec_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_i && sec_o == 8'h59 |=> sec_o == 8'h00 && min_o != $past(min_o));

  p_one_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~dig_sel_no) == 1);

  p_buzz_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_o |-> !buzz_o);

  p_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> min_o == 8'h57 && sec_o >= 8'h10 && sec_o <= 8'h14);
endmodule

bind bcd_alarm_clock bcd_alarm_clock_chk u_chk (
  .clk_i, .rst_ni, .sec_tick_i, .min_o, .sec_o, .dig_sel_no, .alarm_o, .buzz_o
);

// File: tb/bcd_alarm_clock_tb.sv
module bcd_alarm_clock_tb;
  logic clk = 0, rst_n = 0;
  logic sec_t = 0, scan_t = 0, beep_t = 0;
  logic [7:0] min_o, sec_o;
  logic [6:0] seg_o;
  logic [3:0] sel_n;
  logic alarm_o, buzz_o;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // model
  int m_min, m_sec, m_pos, m_cnt;
  bit m_buzz;

  always #2.5 clk = ~clk;

  bcd_alarm_clock u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(sec_t), .scan_tick_i(scan_t),
    .beep_tick_i(beep_t), .min_o, .sec_o, .seg_o, .dig_sel_no(sel_n),
    .alarm_o, .buzz_o
  );

  function automatic logic [6:0] exp_seg(int d);
    logic [6:0] t [10] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,7'h7F,7'h67};
    return t[d];
  endfunction
  function automatic logic [7:0] to_bcd(int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction
  function automatic bit exp_alarm(int mi, int se);
    return mi == 57 && se >= 10 && se <= 14;
  endfunction
  function automatic logic [3:0] exp_sel(int p);
    logic [3:0] t [4] = '{4'b0111, 4'b1011, 4'b1101, 4'b1110};
    return t[p];
  endfunction
  function automatic int exp_digit(int p, int mi, int se);
    case (p)
      0: return se % 10;
      1: return se / 10;
      2: return mi % 10;
      default: return mi / 10;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({"R2/R3 min ", tag}, min_o, to_bcd(m_min));
    chk({"R2/R3 sec ", tag}, sec_o, to_bcd(m_sec));
    chk({"R4 sel ", tag}, sel_n, exp_sel(m_pos));
    chk({"R5 seg ", tag}, seg_o, exp_seg(exp_digit(m_pos, m_min, m_sec)));
    chk({"R6 alarm ", tag}, alarm_o, exp_alarm(m_min, m_sec));
    chk({"R7/R8 buzz ", tag}, buzz_o, m_buzz);
  endtask

  // one cycle: drive at negedge, model updates on edge, check after
  task automatic step(bit s, bit sc, bit b);
    bit in_win;
    @(negedge clk);
    sec_t = s; scan_t = sc; beep_t = b;
    in_win = exp_alarm(m_min, m_sec);
    if (!in_win) begin m_cnt = 0; m_buzz = 0; end
    else if (b) begin
      if (m_cnt == 9) begin m_cnt = 0; m_buzz = !m_buzz; end
      else m_cnt++;
    end
    if (sc) m_pos = (m_pos + 1) % 4;
    if (s) begin
      m_sec++;
      if (m_sec == 60) begin m_sec = 0; m_min = (m_min + 1) % 60; end
    end
    if (!exp_alarm(m_min, m_sec)) m_buzz = 0;
    @(negedge clk);
    sec_t = 0; scan_t = 0; beep_t = 0;
  endtask

  task automatic set_time(int mi, int se);
    while (!(m_min == mi && m_sec == se)) step(1, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_min = 57; m_sec = 5; m_pos = 0; m_cnt = 0; m_buzz = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 min", min_o, 8'h57);
    chk("R1 sec", sec_o, 8'h05);
    chk("R1 sel", sel_n, 4'b0111);
    chk("R1 buzz", buzz_o, 1'b0);

    // R4/R5 full scan, all digit values
    for (int k = 0; k < 40; k++) begin
      step(k % 4 == 0, 1, 0);
      check_all("scan");
    end

    // R7 window: beep ticks, coincident with sec tick at edges
    set_time(57, 9);
    step(1, 0, 1);  // enter window with beep tick
    check_all("enter");
    for (int k = 0; k < 5 * 25; k++) begin
      step((k % 25) == 24, k % 3 == 0, 1);
      check_all("window");
    end
    step(1, 0, 1);
    check_all("exit");

    // R8 beep ticks outside window ignored
    for (int k = 0; k < 30; k++) begin
      step(0, 0, 1);
      check_all("outside");
    end

    // R3 wrap 59:59 -> 00:00
    set_time(59, 59);
    check_all("pre-wrap");
    step(1, 1, 0);
    check_all("wrap");
    chk("R3 wrap min", min_o, 8'h00);
    chk("R3 wrap sec", sec_o, 8'h00);

    // random mix, R2 hold included
    for (int k = 0; k < 3000; k++) begin
      step($urandom % 3 == 0, $urandom % 2, $urandom % 2);
      check_all("rand");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); n_tests++; n_fail++; $display("FAIL watchdog"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule